// File: doc/BRIEF.md
# Ring Oscillator Drift Compensator

This block keeps two 5-bit timing delay taps in step with process, voltage and temperature drift. It drives an external ring oscillator counter through a start/done handshake. Each run takes ten counts and averages them with truncation. The average from the first run after reset becomes the nominal count.

Every later run produces a current count. The block then rescales both taps by nominal divided by current and writes them back in one strobe. All other bits of the delay register are preserved. One sequential divider does the divide by ten and both tap ratios. A busy output covers the whole run.

A run starts with a one-cycle request while the block is idle. The host presents the present delay register value on `dly_in_i`, and the block takes a copy of it in the cycle it accepts the request.

Top module: `drift_comp`

## Requirements
- R1: After reset, busy_o, meas_start_o, dly_we_o, nom_valid_o and err_o are 0 and dly_out_o is all zeros.
- R2: Each accepted run issues exactly 10 one-cycle meas_start_o pulses. The first comes in the cycle after the accepting edge. Each later pulse comes in the cycle after the edge that sampled meas_done_i for the previous measurement. meas_done_i only counts from the second cycle after a start pulse.
- R3: The average is floor(sum of the ten 8-bit meas_count_i values / 10). The first run after reset stores it as the nominal count, sets nom_valid_o, and issues no write.
- R4: On a later run with a nonzero average, each tap becomes ((old tap × nominal) / current) and keeps its low 5 bits. The command tap is dly bits 4:0 and the feedback tap is dly bits 12:8.
- R5: A rescaling run writes once, with a single-cycle dly_we_o. dly_out_o carries both new taps, and every other bit is the dly_in_i value sampled at the accepting edge.
- R6: If the current average is 0, no division is started and no write occurs, and err_o rises. err_o clears at the edge that accepts the next request.
- R7: busy_o is high from the accepting edge until the run ends. A nominal run or a zero run ends 15 edges after the last done edge. A rescaling run raises dly_we_o 43 edges after the last done edge and drops busy_o one edge later.
- R8: A request while busy_o is high is ignored.
- R9: A meas_done_i pulse while no measurement is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | One-cycle run request |
| busy_o | output | 1 | Run in progress |
| meas_start_o | output | 1 | Start one oscillator count |
| meas_done_i | input | 1 | Count finished, meas_count_i valid |
| meas_count_i | input | 8 | Oscillator count result |
| dly_in_i | input | 16 | Present delay register value |
| dly_we_o | output | 1 | Delay register write strobe |
| dly_out_o | output | 16 | New delay register value, valid with dly_we_o |
| nom_valid_o | output | 1 | Nominal count has been stored |
| err_o | output | 1 | Last run measured a zero current count |

## Verification
The start pulse appears one edge after the accepting edge or a done edge. Nominal, error and busy updates appear 15 edges after the last done edge, and the write strobe 43 edges after it. The bench's behavioural model turns each done edge it drives into these due cycles. It then compares busy, start, strobe, written value, nominal flag and error flag against the design at every falling edge. Response latencies vary between measurements, so these offsets are tested relative to the done edges and not to the request.

// File: rtl/drift_pkg.sv
package drift_pkg;

    typedef enum logic [1:0] {
        MS_IDLE,
        MS_START,
        MS_WAIT
    } meas_st_e;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_MEAS,
        CS_AVG,
        CS_SCALE,
        CS_WRITE
    } ctl_st_e;

endpackage

// File: rtl/drift_meas_seq.sv
module drift_meas_seq
    import drift_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int NMEAS = 10,
    parameter int SUM_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    output logic             start_o,
    input  logic             done_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             fin_o,
    output logic [SUM_W-1:0] sum_o
);
    localparam int IDX_W = (NMEAS > 1) ? $clog2(NMEAS) : 1;

    typedef struct packed {
        meas_st_e         st;
        logic [IDX_W-1:0] idx;
        logic [SUM_W-1:0] sum;
        logic             fin;
    } meas_t;

    meas_t q, d;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        case (q.st)
            MS_IDLE: begin
                if (go_i) begin
                    d.st  = MS_START;
                    d.idx = '0;
                    d.sum = '0;
                end
            end
            MS_START: d.st = MS_WAIT;
            MS_WAIT: begin
                if (done_i) begin
                    d.sum = q.sum + SUM_W'(count_i);
                    if (q.idx == IDX_W'(NMEAS - 1)) begin
                        d.st  = MS_IDLE;
                        d.fin = 1'b1;
                    end else begin
                        d.idx = q.idx + IDX_W'(1);
                        d.st  = MS_START;
                    end
                end
            end
            default: d.st = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: MS_IDLE, idx: '0, sum: '0, fin: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign start_o = (q.st == MS_START);
    assign fin_o   = q.fin;
    assign sum_o   = q.sum;

    // R2: index never passes the measurement count
    a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != MS_IDLE) |-> (q.idx < IDX_W'(NMEAS)));
    // R2: completion follows a sampled done
    a_r2_fin_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |-> $past(done_i));
    // R8: controller only launches a series when the sequencer is free
    a_r8_go_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> (q.st == MS_IDLE));

endmodule

// File: rtl/drift_seq_div.sv
module drift_seq_div #(
    parameter int DVD_W = 13,
    parameter int DVS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DVS_W-1:0] divisor_i,
    output logic [DVD_W-1:0] quo_o,
    output logic             done_o
);
    localparam int CW = $clog2(DVD_W + 1);

    typedef struct packed {
        logic             run;
        logic             done;
        logic [CW-1:0]    cnt;
        logic [DVS_W-1:0] dvs;
        logic [DVS_W-1:0] rem;
        logic [DVD_W-1:0] quo;
    } div_t;

    div_t q, d;
    logic [DVS_W:0] trial;
    logic           qbit;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        trial  = {q.rem, q.quo[DVD_W-1]};
        qbit   = 1'b0;
        if (go_i) begin
            d.run = 1'b1;
            d.cnt = CW'(DVD_W);
            d.dvs = divisor_i;
            d.rem = '0;
            d.quo = dividend_i;
        end else if (q.run) begin
            if (trial >= {1'b0, q.dvs}) begin
                d.rem = DVS_W'(trial - {1'b0, q.dvs});
                qbit  = 1'b1;
            end else begin
                d.rem = trial[DVS_W-1:0];
            end
            d.quo = {q.quo[DVD_W-2:0], qbit};
            d.cnt = q.cnt - CW'(1);
            if (q.cnt == CW'(1)) begin
                d.run  = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{run: 1'b0, done: 1'b0, cnt: '0, dvs: '0, rem: '0, quo: '0};
        end else begin
            q <= d;
        end
    end

    assign quo_o  = q.quo;
    assign done_o = q.done;

    // R6: a zero divisor is never launched
    a_r6_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> (divisor_i != '0));
    // R4: no new division while one is in flight
    a_r4_div_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !q.run);
    // R4: completion is a single pulse
    a_r4_div_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

endmodule

// File: rtl/drift_comp.sv
module drift_comp
    import drift_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int NMEAS   = 10,
    parameter int TAP_W   = 5,
    parameter int REG_W   = 16,
    parameter int CMD_LSB = 0,
    parameter int FB_LSB  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    output logic             busy_o,
    output logic             meas_start_o,
    input  logic             meas_done_i,
    input  logic [CNT_W-1:0] meas_count_i,
    input  logic [REG_W-1:0] dly_in_i,
    output logic             dly_we_o,
    output logic [REG_W-1:0] dly_out_o,
    output logic             nom_valid_o,
    output logic             err_o
);
    localparam int NTAP   = 2;
    localparam int TIDX_W = (NTAP > 1) ? $clog2(NTAP) : 1;
    localparam int SUM_W  = CNT_W + $clog2(NMEAS);
    localparam int PROD_W = TAP_W + CNT_W;
    localparam int DIV_W  = (PROD_W > SUM_W) ? PROD_W : SUM_W;

    function automatic int tap_lsb(input int k);
        return (k == 0) ? CMD_LSB : FB_LSB;
    endfunction

    typedef struct packed {
        ctl_st_e                    st;
        logic                       nomv;
        logic                       err;
        logic [CNT_W-1:0]           nom;
        logic [CNT_W-1:0]           cur;
        logic [TIDX_W-1:0]          tidx;
        logic [NTAP-1:0][TAP_W-1:0] tnew;
        logic [REG_W-1:0]           snap;
    } ctl_t;

    ctl_t q, d;

    logic                       meas_go, meas_fin;
    logic [SUM_W-1:0]           meas_sum;
    logic                       div_go, div_done;
    logic [DIV_W-1:0]           div_dvd, div_quo;
    logic [CNT_W-1:0]           div_dvs;
    logic [CNT_W-1:0]           avg;
    logic [NTAP-1:0][TAP_W-1:0] tap_old;
    logic [TIDX_W-1:0]          nxt_idx;

    drift_meas_seq #(.CNT_W(CNT_W), .NMEAS(NMEAS), .SUM_W(SUM_W)) u_meas (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (meas_go),
        .start_o (meas_start_o),
        .done_i  (meas_done_i),
        .count_i (meas_count_i),
        .fin_o   (meas_fin),
        .sum_o   (meas_sum)
    );

    drift_seq_div #(.DVD_W(DIV_W), .DVS_W(CNT_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (div_go),
        .dividend_i (div_dvd),
        .divisor_i  (div_dvs),
        .quo_o      (div_quo),
        .done_o     (div_done)
    );

    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        localparam int LSB = (g == 0) ? CMD_LSB : FB_LSB;
        assign tap_old[g] = q.snap[LSB +: TAP_W];
    end

    assign avg     = div_quo[CNT_W-1:0];
    assign nxt_idx = q.tidx + TIDX_W'(1);

    always_comb begin
        d       = q;
        meas_go = 1'b0;
        div_go  = 1'b0;
        div_dvd = '0;
        div_dvs = '0;
        case (q.st)
            CS_IDLE: begin
                if (req_i) begin
                    d.st    = CS_MEAS;
                    d.snap  = dly_in_i;
                    d.err   = 1'b0;
                    meas_go = 1'b1;
                end
            end
            CS_MEAS: begin
                if (meas_fin) begin
                    d.st    = CS_AVG;
                    div_go  = 1'b1;
                    div_dvd = DIV_W'(meas_sum);
                    div_dvs = CNT_W'(NMEAS);
                end
            end
            CS_AVG: begin
                if (div_done) begin
                    if (!q.nomv) begin
                        d.nom  = avg;
                        d.nomv = 1'b1;
                        d.st   = CS_IDLE;
                    end else if (avg == '0) begin
                        d.err = 1'b1;
                        d.st  = CS_IDLE;
                    end else begin
                        d.cur   = avg;
                        d.tidx  = '0;
                        d.st    = CS_SCALE;
                        div_go  = 1'b1;
                        div_dvd = DIV_W'(q.nom) * DIV_W'(tap_old[0]);
                        div_dvs = avg;
                    end
                end
            end
            CS_SCALE: begin
                if (div_done) begin
                    d.tnew[q.tidx] = div_quo[TAP_W-1:0];
                    if (q.tidx == TIDX_W'(NTAP - 1)) begin
                        d.st = CS_WRITE;
                    end else begin
                        d.tidx  = nxt_idx;
                        div_go  = 1'b1;
                        div_dvd = DIV_W'(q.nom) * DIV_W'(tap_old[nxt_idx]);
                        div_dvs = q.cur;
                    end
                end
            end
            CS_WRITE: d.st = CS_IDLE;
            default:  d.st = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: CS_IDLE, nomv: 1'b0, err: 1'b0, nom: '0, cur: '0,
                   tidx: '0, tnew: '0, snap: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        dly_out_o = q.snap;
        for (int k = 0; k < NTAP; k++) begin
            dly_out_o[tap_lsb(k) +: TAP_W] = q.tnew[k];
        end
    end

    assign busy_o      = (q.st != CS_IDLE);
    assign dly_we_o    = (q.st == CS_WRITE);
    assign nom_valid_o = q.nomv;
    assign err_o       = q.err;

    // R5: write strobe lasts one cycle
    a_r5_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        dly_we_o |=> !dly_we_o);
    // R5: a write only happens once a nominal exists
    a_r5_we_needs_nom: assert property (@(posedge clk) disable iff (!rst_n)
        dly_we_o |-> nom_valid_o);
    // R7: busy covers the write and drops right after it
    a_r7_busy_at_write: assert property (@(posedge clk) disable iff (!rst_n)
        dly_we_o |-> busy_o);
    a_r7_idle_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        dly_we_o |=> !busy_o);
    // R2: start pulses only inside a run
    a_r2_start_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        meas_start_o |-> busy_o);
    // R6: error never coincides with a write, and is clear at run start
    a_r6_no_write_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        dly_we_o |-> !err_o);
    a_r6_err_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !err_o);
    // R3: nominal, once stored, stays
    a_r3_nom_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        nom_valid_o |=> nom_valid_o);
    // R3: the averaged count fits the count width
    a_r3_avg_fits: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == CS_AVG) && div_done) |-> (div_quo[DIV_W-1:CNT_W] == '0));

endmodule

// File: tb/sim_drift_comp.sv
`timescale 1ns/1ps
module sim_drift_comp;
    localparam int NMEAS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        meas_done_i = 1'b0;
    logic [7:0]  meas_count_i = '0;
    logic [15:0] dly_in_i = '0;
    logic        busy_o, meas_start_o, dly_we_o, nom_valid_o, err_o;
    logic [15:0] dly_out_o;

    always #10 clk = ~clk;

    drift_comp u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .busy_o(busy_o),
        .meas_start_o(meas_start_o), .meas_done_i(meas_done_i),
        .meas_count_i(meas_count_i), .dly_in_i(dly_in_i), .dly_we_o(dly_we_o),
        .dly_out_o(dly_out_o), .nom_valid_o(nom_valid_o), .err_o(err_o)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    // stimulus requests from tasks
    int cnt_q[$];
    int lat_q[$];
    bit req_ask = 0;
    bit stray_ask = 0;
    logic [15:0] dly_drv = '0;

    // reference model state
    bit m_act = 0, m_nomv = 0, m_err = 0, m_prev_busy = 0, nom_set = 0;
    int start_e = -1, ndone = 0, sum = 0, end_e = -1, we_e = -1;
    int nomv_e = -1, err_e = -1, done_at = -1, nom = 0;
    logic [15:0] snap = '0, exp_out = '0, last_wr = '0;
    bit req_was = 0, done_was = 0;
    int cnt_was = 0;
    logic [15:0] dly_was = '0;
    int n_start = 0, n_we = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void check(input bit ok, input string tag,
                                  input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endfunction

    function automatic void model_finish(input int e);
        int avg, c, f;
        avg = sum / NMEAS;
        if (!nom_set) begin
            nom_set = 1; nom = avg; nomv_e = e + 15; end_e = e + 15;
        end else if (avg == 0) begin
            err_e = e + 15; end_e = e + 15;
        end else begin
            c = ((int'(snap[4:0]) * nom) / avg) & 31;
            f = ((int'(snap[12:8]) * nom) / avg) & 31;
            exp_out = snap;
            exp_out[4:0] = 5'(c);
            exp_out[12:8] = 5'(f);
            we_e = e + 43; end_e = e + 44;
        end
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            // events sampled at posedge number cyc
            if (req_was && !m_prev_busy) begin
                m_act = 1; start_e = cyc; ndone = 0; sum = 0;
                end_e = -1; we_e = -1; m_err = 0; snap = dly_was;
            end
            if (done_was && m_act && ndone < NMEAS && start_e >= 0 && cyc >= start_e + 2) begin
                sum += cnt_was; ndone++;
                if (ndone < NMEAS) start_e = cyc;
                else begin start_e = -1; model_finish(cyc); end
            end
            if (cyc == nomv_e) m_nomv = 1;
            if (cyc == err_e) m_err = 1;
            if (m_act && end_e >= 0 && cyc >= end_e) m_act = 0;

            check(busy_o == m_act, "R7 busy", busy_o, m_act);
            check(meas_start_o == (m_act && cyc == start_e), "R2 start",
                  meas_start_o, (m_act && cyc == start_e));
            check(dly_we_o == (cyc == we_e), "R5 strobe", dly_we_o, (cyc == we_e));
            if (dly_we_o) begin
                check(dly_out_o == exp_out, "R4 written value", dly_out_o, exp_out);
                last_wr = dly_out_o;
                n_we++;
            end
            if (meas_start_o) n_start++;
            check(nom_valid_o == m_nomv, "R3 nominal flag", nom_valid_o, m_nomv);
            check(err_o == m_err, "R6 error flag", err_o, m_err);
            m_prev_busy = m_act;
        end

        // drive inputs for the next posedge
        done_was = 0;
        if (rst_n && m_act && cyc == start_e) done_at = cyc + 2 + lat_q.pop_front();
        if (rst_n && cyc + 1 == done_at) begin
            cnt_was = cnt_q.pop_front();
            meas_done_i = 1'b1;
            meas_count_i = 8'(cnt_was);
            done_was = 1;
        end else if (stray_ask) begin
            cnt_was = 255;
            meas_done_i = 1'b1;
            meas_count_i = 8'hFF;
            done_was = 1;
            stray_ask = 0;
        end else begin
            meas_done_i = 1'b0;
        end
        req_i = req_ask;
        req_was = req_ask;
        req_ask = 0;
        dly_in_i = dly_drv;
        dly_was = dly_drv;
    end

    task automatic do_run(input int base, input int step, input int lat0,
                          input logic [15:0] dly, input int exp_we,
                          input bit poke, input string tag);
        @(posedge clk); #1;
        for (int i = 0; i < NMEAS; i++) begin
            cnt_q.push_back((base + step * i) & 255);
            lat_q.push_back((lat0 + i) % 4);
        end
        n_start = 0; n_we = 0;
        dly_drv = dly;
        req_ask = 1;
        repeat (3) @(posedge clk);
        #1;
        if (poke) begin
            repeat (4) @(posedge clk);
            #1;
            req_ask = 1;      // R8: ignored while busy
            dly_drv = ~dly;   // R5: snapshot must hold
        end
        while (m_act) @(posedge clk);
        #1;
        check(n_start == NMEAS, {tag, " R2 start count"}, n_start, NMEAS);
        check(n_we == exp_we, {tag, " R5 write count"}, n_we, exp_we);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R1 reset state
        check(busy_o == 0 && meas_start_o == 0 && dly_we_o == 0, "R1 controls", busy_o, 0);
        check(nom_valid_o == 0 && err_o == 0, "R1 flags", err_o, 0);
        check(dly_out_o == 16'h0000, "R1 dly_out_o", dly_out_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;

        // R9: stray done in idle
        stray_ask = 1;
        repeat (3) @(posedge clk);
        #1;
        check(busy_o == 0 && meas_start_o == 0, "R9 stray done", busy_o, 0);

        // R3: first run stores nominal 104 (counts 100..109)
        do_run(100, 1, 0, 16'h1234, 0, 0, "nominal");
        check(nom_valid_o == 1, "R3 nominal stored", nom_valid_o, 1);

        // R4: current 52 -> taps 10,7 become 20,14
        do_run(52, 0, 1, 16'hE7EA, 1, 0, "double");
        check(last_wr == 16'hEEF4, "R4 doubled taps", last_wr, 16'hEEF4);

        // R4: current 1 -> products masked to 5 bits
        do_run(1, 0, 2, 16'h1F05, 1, 0, "mask");
        check(last_wr == 16'h1808, "R4 masked taps", last_wr, 16'h1808);

        // R6: zero current
        do_run(0, 0, 3, 16'h0A0A, 0, 0, "zero");
        check(err_o == 1, "R6 error raised", err_o, 1);

        // R8 and R5: extra request and changed input during a run; R6 clears
        do_run(40, 3, 0, 16'h0310, 1, 1, "poke");
        check(last_wr == 16'h051F, "R5 snapshot kept", last_wr, 16'h051F);
        check(err_o == 0, "R6 error cleared", err_o, 0);

        // R4: current 255, truncating division
        do_run(255, 0, 1, 16'hFF00, 1, 0, "slow");
        check(last_wr == 16'hEC00, "R4 truncated taps", last_wr, 16'hEC00);

        // R9 again between runs
        stray_ask = 1;
        repeat (4) @(posedge clk);
        #1;
        check(busy_o == 0, "R9 stray done idle", busy_o, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R7 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule